// File: doc/BRIEF.md
# Register-Mapped Factorial Engine with Interrupt Status

This block is a small register slave on a 32-bit request/response bus. It exposes a fixed identification word, a scratch register that reads back inverted for bus sanity checks, a factorial engine that software starts with a single write and observes through a busy flag, and an interrupt status register that drives a level-sensitive interrupt line.

Software starts a computation by writing an operand to the factorial register. It then either polls the status register until the busy flag drops, or sets the completion-interrupt enable and waits for the line. Software can also raise arbitrary interrupt causes directly and clear them with a mask write. Each request is accepted in the cycle it is presented. A read returns its data one cycle later, and the returned value is the state that held before that clock edge.

Top module: `calc_irq_slave`

## Requirements
- R1: A read of offset 0x00 returns the parameter ID_VALUE. Writes to 0x00 do not change it.
- R2: A read of offset 0x04 returns the bitwise inverse of the last value written there. After reset it reads 0xFFFFFFFF.
- R3: A write of n to offset 0x08 while idle sets status bit 0 (busy) from the next clock edge. Busy stays set for max(n,1) edges and then clears.
- R4: Once busy has cleared, offset 0x08 reads n! modulo 2^32. Operands 0 and 1 both give 1.
- R5: A write to offset 0x08 while busy is set has no effect on the running computation or on its result.
- R6: Status (offset 0x20) reads 0 after reset. Bit 7 is the completion-interrupt enable, which software can read and write. Writes to bit 0 and to all other bits are ignored.
- R7: When a computation finishes with status bit 7 set, interrupt status bit 0 is set on the same edge that busy clears. With bit 7 clear, interrupt status is left unchanged.
- R8: A write of v to offset 0x60 ORs v into the interrupt status, which is read at offset 0x24.
- R9: A write of mask m to offset 0x64 clears the interrupt status bits that are set in m. If a completion event lands on the same edge, the completion's bit 0 survives.
- R10: The output irq is high exactly when the interrupt status is nonzero, and it is low after reset.
- R11: Reads of any other offset return 0. Writes to unmapped offsets and to read-only registers (0x00, 0x24) have no effect.
- R12: req_ready is always high. rsp_valid pulses one cycle after each accepted read and never after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt, high while any cause is pending |

## Verification
The bench targets the completion edge in particular. It lands an acknowledge write on exactly the edge where a computation ends. A design that applied the clear after the set would lose the completion cause and leave irq low. The bench also writes the factorial register again while a run is in progress. A design that restarted on that write would return 3! instead of 6!. Further stimulus drives 13! to check the result wraps modulo 2^32 and not saturates, and drives 0! and 1! to catch an off-by-one loop bound. The bench writes the read-only and unmapped offsets to catch address aliasing, and writes stray status bits to catch a busy flag that software could force.

// File: rtl/calc_irq_pkg.sv
package calc_irq_pkg;

  localparam int DATA_W = 32;

  // register offsets (bytes)
  localparam int OFF_ID    = 'h00;
  localparam int OFF_LIVE  = 'h04;
  localparam int OFF_FACT  = 'h08;
  localparam int OFF_STAT  = 'h20;
  localparam int OFF_INT   = 'h24;
  localparam int OFF_RAISE = 'h60;
  localparam int OFF_ACK   = 'h64;

  // status register bit positions
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IEN_BIT  = 7;

  // interrupt cause raised by a finished computation
  localparam int CAUSE_DONE_BIT = 0;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_ID,
    RS_LIVE,
    RS_FACT,
    RS_STAT,
    RS_INT
  } rd_sel_e;

  typedef struct packed {
    logic live;
    logic fact;
    logic stat;
    logic raise;
    logic ack;
  } wr_strb_t;

  typedef enum logic {
    FE_IDLE,
    FE_RUN
  } fact_state_e;

endpackage

// File: rtl/calc_reg_decode.sv
module calc_reg_decode
  import calc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output wr_strb_t          wr_strb,
  output logic              rd_fire,
  output rd_sel_e           rd_sel
);

  logic hit_id, hit_live, hit_fact, hit_stat, hit_int, hit_raise, hit_ack;
  logic wr_fire;

  always_comb begin
    hit_id    = (req_addr == ADDR_W'(OFF_ID));
    hit_live  = (req_addr == ADDR_W'(OFF_LIVE));
    hit_fact  = (req_addr == ADDR_W'(OFF_FACT));
    hit_stat  = (req_addr == ADDR_W'(OFF_STAT));
    hit_int   = (req_addr == ADDR_W'(OFF_INT));
    hit_raise = (req_addr == ADDR_W'(OFF_RAISE));
    hit_ack   = (req_addr == ADDR_W'(OFF_ACK));
  end

  always_comb begin
    wr_fire       = req_valid & req_write;
    rd_fire       = req_valid & ~req_write;
    wr_strb.live  = wr_fire & hit_live;
    wr_strb.fact  = wr_fire & hit_fact;
    wr_strb.stat  = wr_fire & hit_stat;
    wr_strb.raise = wr_fire & hit_raise;
    wr_strb.ack   = wr_fire & hit_ack;
  end

  always_comb begin
    rd_sel = RS_NONE;
    if (hit_id)   rd_sel = RS_ID;
    if (hit_live) rd_sel = RS_LIVE;
    if (hit_fact) rd_sel = RS_FACT;
    if (hit_stat) rd_sel = RS_STAT;
    if (hit_int)  rd_sel = RS_INT;
  end

endmodule

// File: rtl/calc_fact_engine.sv
module calc_fact_engine
  import calc_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] value_o
);

  fact_state_e st_q, st_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         last_step;

  always_comb begin
    st_d      = st_q;
    acc_d     = acc_q;
    cnt_d     = cnt_q;
    done_o    = 1'b0;
    last_step = (cnt_q <= W'(1));
    case (st_q)
      FE_IDLE: begin
        if (start_i) begin
          acc_d = W'(1);
          cnt_d = operand_i;
          st_d  = FE_RUN;
        end
      end
      FE_RUN: begin
        if (last_step) begin
          st_d   = FE_IDLE;
          done_o = 1'b1;
        end else begin
          acc_d = acc_q * cnt_q;
          cnt_d = cnt_q - W'(1);
        end
      end
      default: st_d = FE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FE_IDLE;
      acc_q <= W'(1);
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q != st_d || st_q == FE_RUN) begin
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o  = (st_q == FE_RUN);
  assign value_o = acc_q;

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q > W'(1)) |=> busy_o);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  // R5
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R4
  trivial_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && operand_i <= W'(1)) |=> ##1 (!busy_o && value_o == W'(1)));

endmodule

// File: rtl/calc_irq_ctrl.sv
module calc_irq_ctrl
  import calc_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raise_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  input  logic         done_set,
  output logic [W-1:0] status_o,
  output logic         irq_o
);

  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] clr_mask, set_mask;
  logic         stat_en;

  always_comb begin
    clr_mask = ack_we   ? wdata : '0;
    set_mask = raise_we ? wdata : '0;
    set_mask[CAUSE_DONE_BIT] = set_mask[CAUSE_DONE_BIT] | done_set;
    // clear first so a cause arriving on the acknowledge edge is kept
    stat_d  = (stat_q & ~clr_mask) | set_mask;
    stat_en = raise_we | ack_we | done_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status_o = stat_q;
  assign irq_o    = |stat_q;

  // R8
  raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_we |=> ((status_o & $past(wdata)) == $past(wdata)));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !raise_we && !done_set) |=> ((status_o & $past(wdata)) == '0));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(raise_we || done_set));

endmodule

// File: rtl/calc_rd_mux.sv
module calc_rd_mux
  import calc_irq_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [31:0] ID_VALUE = 32'hFAC7_0001
) (
  input  rd_sel_e      rd_sel,
  input  logic [W-1:0] live_val,
  input  logic [W-1:0] fact_val,
  input  logic [W-1:0] stat_val,
  input  logic [W-1:0] int_val,
  output logic [W-1:0] rdata
);

  always_comb begin
    case (rd_sel)
      RS_ID:   rdata = W'(ID_VALUE);
      RS_LIVE: rdata = ~live_val;
      RS_FACT: rdata = fact_val;
      RS_STAT: rdata = stat_val;
      RS_INT:  rdata = int_val;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/calc_irq_slave.sv
module calc_irq_slave
  import calc_irq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'hFAC7_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);

  localparam int W = DATA_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wr_strb_t wr_strb;
  logic     rd_fire;
  rd_sel_e  rd_sel;

  calc_reg_decode #(.ADDR_W(ADDR_W)) i_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_strb   (wr_strb),
    .rd_fire   (rd_fire),
    .rd_sel    (rd_sel)
  );

  // scratch register, read back inverted
  logic [W-1:0] live_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        live_q <= '0;
    else if (wr_strb.live) live_q <= req_wdata;
  end

  // completion-interrupt enable, the only writable status bit
  logic irq_en_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        irq_en_q <= 1'b0;
    else if (wr_strb.stat) irq_en_q <= req_wdata[STAT_IEN_BIT];
  end

  logic         fact_busy, fact_done;
  logic [W-1:0] fact_val;

  calc_fact_engine #(.W(W)) i_fact (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (wr_strb.fact),
    .operand_i (req_wdata),
    .busy_o    (fact_busy),
    .done_o    (fact_done),
    .value_o   (fact_val)
  );

  logic         done_cause;
  logic [W-1:0] int_stat;

  assign done_cause = fact_done & irq_en_q;

  calc_irq_ctrl #(.W(W)) i_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .raise_we (wr_strb.raise),
    .ack_we   (wr_strb.ack),
    .wdata    (req_wdata),
    .done_set (done_cause),
    .status_o (int_stat),
    .irq_o    (irq)
  );

  logic [W-1:0] stat_val;
  always_comb begin
    stat_val = '0;
    stat_val[STAT_BUSY_BIT] = fact_busy;
    stat_val[STAT_IEN_BIT]  = irq_en_q;
  end

  logic [W-1:0] rd_data;

  calc_rd_mux #(.W(W), .ID_VALUE(ID_VALUE)) i_rdmux (
    .rd_sel   (rd_sel),
    .live_val (live_q),
    .fact_val (fact_val),
    .stat_val (stat_val),
    .int_val  (int_stat),
    .rdata    (rd_data)
  );

  logic         rsp_v_q;
  logic [W-1:0] rsp_d_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rsp_v_q <= 1'b0;
    else            rsp_v_q <= rd_fire;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   rsp_d_q <= '0;
    else if (rd_fire) rsp_d_q <= rd_data;
  end

  assign req_ready = 1'b1;
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;

  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fact_done && irq_en_q) |=> (int_stat[CAUSE_DONE_BIT] && irq));

  // R12
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_write) |=> !rsp_valid);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(fact_busy) |-> $past(fact_done));

endmodule

// File: tb/test_calc_irq_slave.sv
module test_calc_irq_slave;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam logic [31:0] ID_V = 32'hFAC7_0001;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          req_ready, rsp_valid, irq;
  logic [31:0]   rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  calc_irq_slave #(.ADDR_W(AW), .ID_VALUE(ID_V)) i_calc_irq_slave (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R12";

  // behavioural reference state
  int unsigned m_live = 0;
  bit          m_en = 0;
  bit          m_busy = 0;
  int unsigned m_acc = 1;
  int unsigned m_cnt = 0;
  int unsigned m_int = 0;
  bit          m_rv = 0;
  int unsigned m_rd = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned model_read(input logic [AW-1:0] a);
    case (a)
      8'h00: return ID_V;
      8'h04: return ~m_live;
      8'h08: return m_acc;
      8'h20: return (m_en ? 32'h80 : 32'h0) | (m_busy ? 32'h1 : 32'h0);
      8'h24: return m_int;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit          done = 0;
    bit          old_en = m_en;
    bit          rd = req_valid && !req_write;
    bit          wr = req_valid && req_write;
    int unsigned rdv = model_read(req_addr);
    if (m_busy) begin
      if (m_cnt <= 1) begin m_busy = 0; done = 1; end
      else begin m_acc = m_acc * m_cnt; m_cnt = m_cnt - 1; end
    end else if (wr && req_addr == 8'h08) begin
      m_acc = 1; m_cnt = req_wdata; m_busy = 1;
    end
    if (wr && req_addr == 8'h04) m_live = req_wdata;
    if (wr && req_addr == 8'h20) m_en = req_wdata[7];
    if (wr && req_addr == 8'h64) m_int = m_int & ~req_wdata;
    if (wr && req_addr == 8'h60) m_int = m_int | req_wdata;
    if (done && old_en) m_int = m_int | 32'h1;
    m_rv = rd;
    if (rd) m_rd = rdv;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur_req, {31'b0, rsp_valid}, {31'b0, m_rv}, "rsp_valid");
    if (m_rv) check(cur_req, rsp_rdata, m_rd, "rsp_rdata");
    check("R10", {31'b0, irq}, {31'b0, (m_int != 0)}, "irq");
    check("R12", {31'b0, req_ready}, 32'h1, "req_ready");
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [31:0] d, output logic [31:0] rd);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    tick();
    rd = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr32(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] unused_rd;
    xfer(1'b1, a, d, unused_rd);
  endtask

  task automatic rd32(input logic [AW-1:0] a, output logic [31:0] d);
    xfer(1'b0, a, 32'h0, d);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd32(8'h20, s);
      if (!s[0]) break;
    end
  endtask

  task automatic fact_run(input int unsigned n, input int unsigned exp, input string req);
    logic [31:0] v;
    wr32(8'h08, n);
    wait_idle();
    rd32(8'h08, v);
    check(req, v, exp, $sformatf("factorial of %0d", n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // reset state
    cur_req = "R6";  rd32(8'h20, v); check("R6", v, 32'h0, "status after reset");
    cur_req = "R1";  rd32(8'h00, v); check("R1", v, ID_V, "id");
    cur_req = "R2";  rd32(8'h04, v); check("R2", v, 32'hFFFF_FFFF, "live after reset");
    cur_req = "R10"; rd32(8'h24, v); check("R10", v, 32'h0, "int status after reset");

    // liveness inversion
    cur_req = "R2";
    wr32(8'h04, 32'hDEAD_BEEF); rd32(8'h04, v); check("R2", v, 32'h2152_4110, "live inverse");
    wr32(8'h04, 32'h0000_00FF); rd32(8'h04, v); check("R2", v, 32'hFFFF_FF00, "live inverse 2");

    // factorial by polling
    cur_req = "R3"; wr32(8'h20, 32'h0);
    wr32(8'h08, 32'd4);
    rd32(8'h20, v); check("R3", v, 32'h1, "busy after start");
    wait_idle();
    rd32(8'h20, v); check("R3", v, 32'h0, "busy cleared");
    cur_req = "R4";
    fact_run(10, 3628800, "R4");
    fact_run(0, 1, "R4");
    fact_run(1, 1, "R4");
    fact_run(12, 479001600, "R4");
    fact_run(13, 32'h7328_CC00, "R4");

    // restart while busy ignored
    cur_req = "R5";
    wr32(8'h08, 32'd6);
    wr32(8'h08, 32'd3);
    wait_idle();
    rd32(8'h08, v); check("R5", v, 32'd720, "restart while busy");

    // status bit write filtering
    cur_req = "R6";
    wr32(8'h20, 32'hFFFF_FFFF); rd32(8'h20, v); check("R6", v, 32'h80, "status write mask");
    wr32(8'h20, 32'h0000_0001); rd32(8'h20, v); check("R6", v, 32'h0, "busy not writable");

    // completion interrupt
    cur_req = "R7";
    wr32(8'h20, 32'h80);
    fact_run(5, 120, "R7");
    rd32(8'h24, v); check("R7", v, 32'h1, "done cause");
    check("R7", {31'b0, irq}, 32'h1, "irq on done");
    cur_req = "R9";
    wr32(8'h64, 32'hFFFF_FFFF); rd32(8'h24, v); check("R9", v, 32'h0, "ack all");
    check("R10", {31'b0, irq}, 32'h0, "irq low after ack");

    // raise and partial acknowledge
    cur_req = "R8";
    wr32(8'h60, 32'hDEAD_BEEF); rd32(8'h24, v); check("R8", v, 32'hDEAD_BEEF, "raise");
    wr32(8'h60, 32'h0000_0010); rd32(8'h24, v); check("R8", v, 32'hDEAD_BEFF, "raise OR");
    cur_req = "R9";
    wr32(8'h64, 32'h0000_FFFF); rd32(8'h24, v); check("R9", v, 32'hDEAD_0000, "partial ack");
    check("R10", {31'b0, irq}, 32'h1, "irq still high");
    wr32(8'h64, 32'hFFFF_FFFF);

    // acknowledge on the completion edge
    cur_req = "R9";
    wr32(8'h08, 32'd2);
    tick();
    wr32(8'h64, 32'hFFFF_FFFF);
    rd32(8'h24, v); check("R9", v, 32'h1, "done beats ack on same edge");
    wr32(8'h64, 32'h1);

    // no cause with enable clear
    cur_req = "R7";
    wr32(8'h20, 32'h0);
    fact_run(4, 24, "R7");
    rd32(8'h24, v); check("R7", v, 32'h0, "no cause when disabled");

    // read-only and unmapped
    cur_req = "R11";
    wr32(8'h00, 32'h1234_5678); rd32(8'h00, v); check("R1", v, ID_V, "id write ignored");
    wr32(8'h24, 32'hFFFF_FFFF); rd32(8'h24, v); check("R11", v, 32'h0, "int status read-only");
    check("R11", {31'b0, irq}, 32'h0, "irq after ro write");
    wr32(8'h10, 32'hFFFF_FFFF); rd32(8'h10, v); check("R11", v, 32'h0, "unmapped 0x10");
    rd32(8'hFC, v); check("R11", v, 32'h0, "unmapped 0xFC");
    rd32(8'h06, v); check("R11", v, 32'h0, "unaligned");
    rd32(8'h04, v); check("R11", v, 32'hFFFF_FF00, "live kept after stray writes");

    cur_req = "R12";
    repeat (4) tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule